// File: doc/BRIEF.md
# Early-Skip Radix-4 Integer Divider

This block is a multi-cycle integer divider for an integer execution pipeline. It takes two XLEN-bit operands and an operation code through a valid/ready command port. It returns either the quotient or the remainder, for signed or unsigned operands, on a result port that pulses valid for one cycle. Each iteration cycle runs two chained restoring subtract steps, so two quotient bits are resolved per clock.

When a command is accepted, the unit takes the magnitude of the dividend and looks at its most significant quarters. Each quarter is XLEN/4 bits wide. Every quarter that is entirely zero, counted from the top, is skipped, to a maximum of three. The dividend is pre-shifted past those quarters and the iteration count is reduced to match, so small dividends return early.

A zero divisor bypasses iteration entirely. An abort input drops the operation in flight without producing a result.

Top module: `radix4_divider`

## Requirements
- R1: `cmd_op` encodes the operation: 2'b00 signed quotient, 2'b01 unsigned quotient, 2'b10 signed remainder, 2'b11 unsigned remainder. For the unsigned codes with a nonzero divisor, `res_data` equals a/b or a%b of the unsigned operands.
- R2: For the signed codes with a nonzero divisor and no overflow, the quotient is truncated toward zero and is negative when the operand signs differ. The remainder carries the sign of the dividend.
- R3: A zero divisor yields an all-ones quotient (signed and unsigned) and a remainder equal to the dividend.
- R4: Signed division of the most negative value by -1 yields the dividend as quotient and zero as remainder.
- R5: `cmd_ready` is high exactly when the unit is idle. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_valid` and the operands are ignored while busy.
- R6: With a nonzero divisor, let k be the number of all-zero XLEN/4-bit chunks at the top of the dividend magnitude, capped at 3. `res_valid` rises (4-k)*XLEN/8 + 1 clock edges after the accepting edge.
- R7: With a zero divisor, `res_valid` rises one clock edge after the accepting edge.
- R8: `res_valid` is high for exactly one cycle per result, and `res_data` holds its value until the next result.
- R9: `abort` high on an edge while busy returns the unit to idle with no result for that command, and `cmd_ready` is high after that edge.
- R10: After reset, `cmd_ready` is 1, `res_valid` is 0 and `res_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Unit idle, command can be taken |
| cmd_op | input | 2 | Operation code (see R1) |
| cmd_a | input | XLEN | Dividend |
| cmd_b | input | XLEN | Divisor |
| abort | input | 1 | Cancel the operation in flight |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | XLEN | Quotient or remainder |

## Verification
The bench aims at the skip boundaries. These are dividends whose top nonzero bit sits at the first or last bit of a chunk, plus zero and all-ones dividends. A wrong chunk count or a wrong pre-shift shows up either as a latency off by a multiple of XLEN/8 cycles or as a quotient scaled by a power of two. Signed cases cover every sign combination of operands, the most-negative/-1 overflow, and a zero divisor with negative dividends. A misplaced sign fix would negate a remainder or saturate the overflow quotient. Abort and busy-time command traffic are driven mid-operation; a unit that leaked state would emit a stray strobe or a result built from the later operands.

// File: rtl/rdiv_pkg.sv
package rdiv_pkg;
    typedef enum logic [1:0] {
        OP_DIV  = 2'b00,
        OP_DIVU = 2'b01,
        OP_REM  = 2'b10,
        OP_REMU = 2'b11
    } div_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ITER = 2'd1,
        ST_FIX  = 2'd2
    } div_state_e;

    localparam int CHUNKS = 4;
    localparam int MAX_SKIP = CHUNKS - 1;
endpackage

// File: rtl/rdiv_prep.sv
module rdiv_prep #(
    parameter int XLEN = 32
) (
    input  logic            is_signed,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] mag_b,
    output logic [XLEN-1:0] shifted_a,
    output logic            sign_a,
    output logic            sign_b,
    output logic [1:0]      skip
);
    import rdiv_pkg::*;
    localparam int CHUNK = XLEN / CHUNKS;

    logic [XLEN-1:0]   mag_a;
    logic [CHUNKS-1:0] top_zero;

    assign sign_a = is_signed & a[XLEN-1];
    assign sign_b = is_signed & b[XLEN-1];
    assign mag_a  = sign_a ? (~a + 1'b1) : a;
    assign mag_b  = sign_b ? (~b + 1'b1) : b;

    // top_zero[k]: chunk k counted from the most significant end is empty
    for (genvar k = 0; k < CHUNKS; k++) begin : g_chunk
        assign top_zero[k] = (mag_a[XLEN-1-k*CHUNK -: CHUNK] == '0);
    end

    always_comb begin
        logic run;
        run  = 1'b1;
        skip = '0;
        for (int k = 0; k < MAX_SKIP; k++) begin
            if (run && top_zero[k]) begin
                skip = skip + 2'd1;
            end else begin
                run = 1'b0;
            end
        end
    end

    assign shifted_a = mag_a << (int'(skip) * CHUNK);
endmodule

// File: rtl/rdiv_step.sv
module rdiv_step #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] rem_i,
    input  logic [XLEN-1:0] dvd_i,
    input  logic [XLEN-1:0] dsr,
    output logic [XLEN-1:0] rem_o,
    output logic [XLEN-1:0] dvd_o
);
    logic [XLEN:0] trial;
    logic [XLEN:0] diff;
    logic          fits;

    assign trial = {rem_i, dvd_i[XLEN-1]};
    assign diff  = trial - {1'b0, dsr};
    assign fits  = (trial >= {1'b0, dsr});
    assign rem_o = fits ? diff[XLEN-1:0] : trial[XLEN-1:0];
    assign dvd_o = {dvd_i[XLEN-2:0], fits};
endmodule

// File: rtl/rdiv_fix.sv
module rdiv_fix #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] quo,
    input  logic [XLEN-1:0] rem,
    input  logic [XLEN-1:0] orig_a,
    input  logic            neg_q,
    input  logic            neg_r,
    input  logic            want_rem,
    input  logic            div_zero,
    output logic [XLEN-1:0] result
);
    always_comb begin
        if (div_zero) begin
            result = want_rem ? orig_a : '1;
        end else if (want_rem) begin
            result = neg_r ? (~rem + 1'b1) : rem;
        end else begin
            result = neg_q ? (~quo + 1'b1) : quo;
        end
    end
endmodule

// File: rtl/radix4_divider.sv
module radix4_divider #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    output logic            cmd_ready,
    input  logic [1:0]      cmd_op,
    input  logic [XLEN-1:0] cmd_a,
    input  logic [XLEN-1:0] cmd_b,
    input  logic            abort,
    output logic            res_valid,
    output logic [XLEN-1:0] res_data
);
    import rdiv_pkg::*;

    localparam int STEPS      = 2;
    localparam int CHUNK      = XLEN / CHUNKS;
    localparam int ITER_CHUNK = CHUNK / STEPS;
    localparam int MAX_ITER   = ITER_CHUNK * CHUNKS;
    localparam int CW         = $clog2(MAX_ITER);

    typedef struct packed {
        div_state_e      state;
        logic [CW-1:0]   cnt;
        logic [XLEN-1:0] rem;
        logic [XLEN-1:0] dvd;
        logic [XLEN-1:0] dsr;
        logic [XLEN-1:0] orig_a;
        logic            neg_q;
        logic            neg_r;
        logic            want_rem;
        logic            div_zero;
        logic [XLEN-1:0] res;
        logic            res_valid;
    } div_regs_t;

    div_regs_t d, q;

    logic [XLEN-1:0] mag_b, shifted_a, fix_out;
    logic            sign_a, sign_b;
    logic [1:0]      skip;
    logic [XLEN-1:0] rem_chain [STEPS+1];
    logic [XLEN-1:0] dvd_chain [STEPS+1];

    rdiv_prep #(.XLEN(XLEN)) u_prep (
        .is_signed (~cmd_op[0]),
        .a         (cmd_a),
        .b         (cmd_b),
        .mag_b     (mag_b),
        .shifted_a (shifted_a),
        .sign_a    (sign_a),
        .sign_b    (sign_b),
        .skip      (skip)
    );

    assign rem_chain[0] = q.rem;
    assign dvd_chain[0] = q.dvd;

    for (genvar g = 0; g < STEPS; g++) begin : g_step
        rdiv_step #(.XLEN(XLEN)) u_step (
            .rem_i (rem_chain[g]),
            .dvd_i (dvd_chain[g]),
            .dsr   (q.dsr),
            .rem_o (rem_chain[g+1]),
            .dvd_o (dvd_chain[g+1])
        );
    end

    rdiv_fix #(.XLEN(XLEN)) u_fix (
        .quo      (q.dvd),
        .rem      (q.rem),
        .orig_a   (q.orig_a),
        .neg_q    (q.neg_q),
        .neg_r    (q.neg_r),
        .want_rem (q.want_rem),
        .div_zero (q.div_zero),
        .result   (fix_out)
    );

    always_comb begin
        d           = q;
        d.res_valid = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                if (cmd_valid) begin
                    d.rem      = '0;
                    d.dvd      = shifted_a;
                    d.dsr      = mag_b;
                    d.orig_a   = cmd_a;
                    d.neg_q    = sign_a ^ sign_b;
                    d.neg_r    = sign_a;
                    d.want_rem = cmd_op[1];
                    d.div_zero = (cmd_b == '0);
                    d.cnt      = CW'(ITER_CHUNK * (CHUNKS - int'(skip)) - 1);
                    d.state    = (cmd_b == '0) ? ST_FIX : ST_ITER;
                end
            end
            ST_ITER: begin
                if (abort) begin
                    d.state = ST_IDLE;
                end else begin
                    d.rem = rem_chain[STEPS];
                    d.dvd = dvd_chain[STEPS];
                    if (q.cnt == '0) begin
                        d.state = ST_FIX;
                    end else begin
                        d.cnt = q.cnt - 1'b1;
                    end
                end
            end
            ST_FIX: begin
                d.state = ST_IDLE;
                if (!abort) begin
                    d.res       = fix_out;
                    d.res_valid = 1'b1;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign cmd_ready = (q.state == ST_IDLE);
    assign res_valid = q.res_valid;
    assign res_data  = q.res;
endmodule

// File: rtl/rdiv_checker.sv
module rdiv_checker #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cmd_valid,
    input logic            cmd_ready,
    input logic [XLEN-1:0] cmd_b,
    input logic            abort,
    input logic            res_valid,
    input logic [XLEN-1:0] res_data
);
    localparam int LAT_MAX = XLEN / 2 + 1;

    logic [7:0] busy_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_cnt <= '0;
        end else if (cmd_valid && cmd_ready) begin
            busy_cnt <= '0;
        end else if (!cmd_ready && busy_cnt != 8'hFF) begin
            busy_cnt <= busy_cnt + 8'd1;
        end
    end

    AST_RES_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid); // R8
    AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> $stable(res_data)); // R8
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready); // R5
    AST_RES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> cmd_ready); // R5
    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_ready && abort) |=> (cmd_ready && !res_valid)); // R9
    AST_ZERO_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_b == '0) ##1 !abort |=> res_valid); // R7
    AST_LAT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (busy_cnt <= 8'(LAT_MAX))); // R6
endmodule

bind radix4_divider rdiv_checker #(.XLEN(XLEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_b     (cmd_b),
    .abort     (abort),
    .res_valid (res_valid),
    .res_data  (res_data)
);

// File: tb/sim_radix4_divider.sv
module sim_radix4_divider;
    localparam int XLEN       = 32;
    localparam int CLK_PERIOD = 10;
    localparam int CHUNK      = XLEN / 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cmd_valid = 1'b0;
    logic            cmd_ready;
    logic [1:0]      cmd_op = 2'b00;
    logic [XLEN-1:0] cmd_a = '0;
    logic [XLEN-1:0] cmd_b = '0;
    logic            abort = 1'b0;
    logic            res_valid;
    logic [XLEN-1:0] res_data;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    radix4_divider #(.XLEN(XLEN)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_a(cmd_a), .cmd_b(cmd_b), .abort(abort),
        .res_valid(res_valid), .res_data(res_data)
    );

    function automatic logic [XLEN-1:0] exp_res(logic [1:0] op, logic [XLEN-1:0] a, logic [XLEN-1:0] b);
        logic signed [XLEN-1:0] sa, sb;
        sa = a; sb = b;
        if (b == '0) return op[1] ? a : '1;
        if (op[0]) return op[1] ? (a % b) : (a / b);
        if (a == {1'b1, {(XLEN-1){1'b0}}} && b == '1) return op[1] ? '0 : a;
        return op[1] ? XLEN'(sa % sb) : XLEN'(sa / sb);
    endfunction

    function automatic int exp_lat(logic [1:0] op, logic [XLEN-1:0] a, logic [XLEN-1:0] b);
        logic [XLEN-1:0] m;
        int k;
        if (b == '0) return 1;
        m = (!op[0] && a[XLEN-1]) ? (~a + 1'b1) : a;
        k = 0;
        for (int i = 0; i < 3; i++) begin
            if (m[XLEN-1-i*CHUNK -: CHUNK] != '0) break;
            k++;
        end
        return (4 - k) * (XLEN / 8) + 1;
    endfunction

    task automatic chk(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive one command, wait for the strobe, check value and latency
    task automatic run_op(input string req, input logic [1:0] op,
                          input logic [XLEN-1:0] a, input logic [XLEN-1:0] b);
        int lat;
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_a = a; cmd_b = b;
        @(negedge clk);
        cmd_valid = 1'b0;
        lat = 0;
        while (!res_valid && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        chk(req, res_data, exp_res(op, a, b));
        chk((b == '0) ? "R7 latency" : "R6 latency", XLEN'(lat), XLEN'(exp_lat(op, a, b)));
        @(negedge clk);
        chk("R8 single-cycle strobe", {31'b0, res_valid}, '0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R6 actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [XLEN-1:0] held;
        logic [XLEN-1:0] ra, rb;
        logic [1:0] rop;
        int seen;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk("R10 ready after reset", {31'b0, cmd_ready}, 32'd1);
        chk("R10 valid after reset", {31'b0, res_valid}, '0);
        chk("R10 data after reset", res_data, '0);
        rst_n = 1'b1;

        // R1 unsigned, chunk boundaries for R6
        run_op("R1 divu", 2'b01, 32'd100, 32'd7);
        run_op("R1 remu", 2'b11, 32'd100, 32'd7);
        run_op("R1 divu top bit", 2'b01, 32'hFFFF_FFFF, 32'd3);
        run_op("R1 remu chunk edge", 2'b11, 32'h0100_0000, 32'd5);
        run_op("R1 divu chunk edge", 2'b01, 32'h00FF_FFFF, 32'd9);
        run_op("R1 divu small", 2'b01, 32'h0000_00FF, 32'd2);
        run_op("R1 divu zero dividend", 2'b01, 32'd0, 32'd5);
        run_op("R1 divu big divisor", 2'b01, 32'd5, 32'hFFFF_FFF0);
        // R2 signs
        run_op("R2 div neg/pos", 2'b00, -32'sd7, 32'sd2);
        run_op("R2 rem neg/pos", 2'b10, -32'sd7, 32'sd2);
        run_op("R2 div pos/neg", 2'b00, 32'sd7, -32'sd2);
        run_op("R2 rem pos/neg", 2'b10, 32'sd7, -32'sd2);
        run_op("R2 div neg/neg", 2'b00, -32'sd100, -32'sd9);
        run_op("R2 rem neg/neg", 2'b10, -32'sd100, -32'sd9);
        // R3 zero divisor
        run_op("R3 div by zero", 2'b00, -32'sd5, 32'd0);
        run_op("R3 divu by zero", 2'b01, 32'd12345, 32'd0);
        run_op("R3 rem by zero", 2'b10, -32'sd5, 32'd0);
        run_op("R3 remu by zero", 2'b11, 32'hDEAD_BEEF, 32'd0);
        // R4 overflow
        run_op("R4 overflow quotient", 2'b00, 32'h8000_0000, 32'hFFFF_FFFF);
        run_op("R4 overflow remainder", 2'b10, 32'h8000_0000, 32'hFFFF_FFFF);

        // R9 abort mid-iteration
        held = res_data;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'b01; cmd_a = 32'hFFFF_0000; cmd_b = 32'd3;
        @(negedge clk);
        cmd_valid = 1'b0;
        @(negedge clk);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        chk("R9 ready after abort", {31'b0, cmd_ready}, 32'd1);
        seen = 0;
        repeat (25) begin
            @(negedge clk);
            if (res_valid) seen++;
        end
        chk("R9 no strobe after abort", XLEN'(seen), '0);
        chk("R8 data held after abort", res_data, held);
        run_op("R9 op after abort", 2'b01, 32'd1000, 32'd10);

        // R5 commands while busy are ignored
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'b01; cmd_a = 32'd77; cmd_b = 32'd7;
        @(negedge clk);
        cmd_a = 32'd999; cmd_b = 32'd2; cmd_op = 2'b11;
        chk("R5 not ready while busy", {31'b0, cmd_ready}, '0);
        seen = 0;
        while (!res_valid && seen < 100) begin
            @(negedge clk);
            seen++;
        end
        cmd_valid = 1'b0;
        chk("R5 busy operands ignored", res_data, 32'd11);
        repeat (3) @(negedge clk);
        chk("R5 no extra command", {31'b0, cmd_ready}, 32'd1);

        // random mix
        for (int i = 0; i < 400; i++) begin
            rop = 2'($urandom);
            ra = $urandom;
            rb = $urandom;
            case ($urandom % 6)
                0: ra = ra >> ($urandom % XLEN);
                1: rb = rb >> ($urandom % XLEN);
                2: rb = '0;
                3: begin ra = ra >> ($urandom % XLEN); if (ra[0]) ra = ~ra + 1'b1; end
                default: ;
            endcase
            run_op(rop[0] ? (rop[1] ? "R1 random remu" : "R1 random divu")
                          : (rop[1] ? "R2 random rem" : "R2 random div"), rop, ra, rb);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule